// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block decides whether the processor core should be interrupted, and with which 8-bit vector. It takes eight external request pins, two on-chip timer requests and one non-maskable request. The pins work in one of two modes. In dedicated mode each pin is its own source, with its own vector and a choice of edge or level triggering. In expanded mode the eight pins together carry an encoded vector, so one port can address 240 sources.

The priority of every vector is its upper five bits. A maskable source can interrupt the core only when its priority is strictly higher than the current process priority that the core supplies. The non-maskable source always wins and ignores that priority. The winner appears on a registered request/vector pair. The core acknowledges it with a one-cycle pulse, and that pulse clears a latched request belonging to the presented source.

Configuration is written through a simple select/data port.

Top module: `irq_prio_ctl`

## Requirements
- R1: While `rst_n` is low, `irq_req` and `irq_vec` are 0. Reset also clears every configured vector to 0, makes every pin level-triggered and selects dedicated mode.
- R2: A level-triggered pin requests from the first clock edge at which it is sampled high. Its request drops at the first edge at which it is sampled low, with no acknowledge needed.
- R3: An edge-triggered pin (configuration bit 8 set) latches a rising edge and presents it from the next edge onward. The latch clears only when `irq_ack` is high while `irq_req` shows that source, and `irq_req` is low from the following edge. An acknowledge never clears a level-triggered pin.
- R4: The priority of a vector is bits [7:3]. A maskable source is eligible only when that priority is strictly greater than `cur_pri`. A latched edge that is blocked stays pending and is presented once `cur_pri` falls below its priority.
- R5: Among eligible sources the highest priority wins. On equal priority the lower source index wins, where pins are indices 0 to 7 and timers are indices 8 and 9.
- R6: A vector below 16 never raises a request, whether it is configured or encoded on the pins. `irq_vec` is 0 whenever `irq_req` is 0.
- R7: In expanded mode the value on `irq_pin` is a vector code. It competes as source index 0 for as long as it is held, and the per-pin vector and trigger settings are ignored.
- R8: A rising edge on `nmi_in` is latched. It is presented with vector `NMI_VEC` (default 0xF8) ahead of every maskable source, whatever the value of `cur_pri`. Only an acknowledge of that presentation clears it.
- R9: Each timer request latches on its rising edge and behaves like an edge-triggered pin, using the vector configured for that timer.
- R10: A write happens when `cfg_we` is high at a clock edge. `cfg_sel` 0 to 7 selects a pin, taking its vector from `cfg_wdata[7:0]` and its trigger from `cfg_wdata[8]` (1 = edge). `cfg_sel` 8 and 9 select the vectors of timers 0 and 1. `cfg_sel` 10 sets the mode from `cfg_wdata[0]` (1 = expanded).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin | input | 8 | External request pins or encoded vector |
| tmr_irq | input | 2 | Timer request lines |
| nmi_in | input | 1 | Non-maskable request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration target select |
| cfg_wdata | input | 9 | Configuration write data |
| cur_pri | input | 5 | Current process priority |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector of the presented request |
| irq_ack | input | 1 | Core acknowledge of the presented request |

## Verification
The assertions check four things on every cycle:
- a maskable vector on the output always beats the process priority that was sampled one edge before;
- no vector below 16 is ever presented;
- a pending non-maskable request takes the output at the next edge;
- a valid expanded code that outranks the priority is presented unchanged.

Some behaviours need a sequence of stimulus, so only the bench scenarios can show them:
- an edge latch surviving until its own acknowledge;
- a blocked edge released when the priority drops;
- tie ordering between the pins and between the two timers;
- an acknowledge leaving a level pin untouched;
- configuration writes and the defaults that reset restores.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W   = 8;
  localparam int PRI_W   = 5;
  localparam int PRI_LSB = VEC_W - PRI_W;
  localparam int MIN_VEC = 16;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [PRI_W-1:0] pri_t;

  // priority class carried in the top bits of a vector
  function automatic pri_t vec_pri(vec_t v);
    return v[VEC_W-1:PRI_LSB];
  endfunction

  function automatic logic vec_ok(vec_t v);
    return int'(v) >= MIN_VEC;
  endfunction

  // a vector may interrupt only above the running priority
  function automatic logic beats_floor(vec_t v, pri_t floor);
    return vec_ok(v) && (vec_pri(v) > floor);
  endfunction
endpackage

// File: rtl/irq_src_stage.sv
module irq_src_stage #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] is_edge,
  input  logic [N-1:0] clr,
  output logic [N-1:0] act
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic [N-1:0] rise;

  assign rise = raw & ~prev_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    // edge sources: latched rising edge, masked by a clear in flight
    // level sources: follow the input directly
    assign act[g]    = is_edge[g] ? ((pend_q[g] | rise[g]) & ~clr[g]) : raw[g];
    assign pend_d[g] = is_edge[g] & (rise[g] | (pend_q[g] & ~clr[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= raw;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NSRC  = 10,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  act,
  input  vec_t [NSRC-1:0]  vecs,
  input  pri_t             floor,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output vec_t             vec
);
  pri_t best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    vec   = '0;
    best  = '0;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int i = 0; i < NSRC; i++) begin
      if (act[i] && beats_floor(vecs[i], floor) &&
          (!found || vec_pri(vecs[i]) > best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        vec   = vecs[i];
        best  = vec_pri(vecs[i]);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_pkg::*;
#(
  parameter int   NTMR    = 2,
  parameter vec_t NMI_VEC = 8'hF8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [VEC_W-1:0]                     irq_pin,
  input  logic [NTMR-1:0]                      tmr_irq,
  input  logic                                 nmi_in,
  input  logic                                 cfg_we,
  input  logic [$clog2(VEC_W+NTMR+1)-1:0]      cfg_sel,
  input  logic [VEC_W:0]                       cfg_wdata,
  input  logic [PRI_W-1:0]                     cur_pri,
  output logic                                 irq_req,
  output logic [VEC_W-1:0]                     irq_vec,
  input  logic                                 irq_ack
);
  localparam int NPINS     = VEC_W;
  localparam int NSRC      = NPINS + NTMR;
  localparam int IDX_W     = $clog2(NSRC);
  localparam int CFG_SEL_W = $clog2(NSRC + 1);
  localparam int MODE_SEL  = NSRC;

  // configuration state
  vec_t [NPINS-1:0] pin_vec_q;
  logic [NPINS-1:0] pin_edge_q;
  vec_t [NTMR-1:0]  tmr_vec_q;
  logic             exp_mode_q;

  // presented-source bookkeeping
  logic [IDX_W-1:0] src_q;
  logic             nmi_sel_q;

  // named internal events
  logic             ack_hit;
  logic [NSRC-1:0]  clr_all;
  logic             nmi_clr;
  logic [NPINS-1:0] pin_act;
  logic [NTMR-1:0]  tmr_act;
  logic             nmi_act;
  logic [NSRC-1:0]  cand_act;
  vec_t [NSRC-1:0]  cand_vec;
  logic             win_found;
  logic [IDX_W-1:0] win_idx;
  vec_t             win_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_vec_q  <= '0;
      pin_edge_q <= '0;
      tmr_vec_q  <= '0;
      exp_mode_q <= 1'b0;
    end else if (cfg_we) begin
      for (int i = 0; i < NPINS; i++) begin
        if (cfg_sel == CFG_SEL_W'(i)) begin
          pin_vec_q[i]  <= cfg_wdata[VEC_W-1:0];
          pin_edge_q[i] <= cfg_wdata[VEC_W];
        end
      end
      for (int t = 0; t < NTMR; t++) begin
        if (cfg_sel == CFG_SEL_W'(NPINS + t)) tmr_vec_q[t] <= cfg_wdata[VEC_W-1:0];
      end
      if (cfg_sel == CFG_SEL_W'(MODE_SEL)) exp_mode_q <= cfg_wdata[0];
    end
  end

  // acknowledge retires the source currently on the output
  assign ack_hit = irq_ack && irq_req;
  assign nmi_clr = ack_hit && nmi_sel_q;

  always_comb begin
    clr_all = '0;
    if (ack_hit && !nmi_sel_q) clr_all[src_q] = 1'b1;
  end

  irq_src_stage #(.N(NPINS)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw     (irq_pin),
    .is_edge (pin_edge_q),
    .clr     (clr_all[NPINS-1:0] | {NPINS{exp_mode_q}}),
    .act     (pin_act)
  );

  irq_src_stage #(.N(NTMR)) u_tmrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw     (tmr_irq),
    .is_edge ({NTMR{1'b1}}),
    .clr     (clr_all[NSRC-1:NPINS]),
    .act     (tmr_act)
  );

  irq_src_stage #(.N(1)) u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw     (nmi_in),
    .is_edge (1'b1),
    .clr     (nmi_clr),
    .act     (nmi_act)
  );

  // candidate list: expanded mode replaces the pins with one encoded source
  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      if (exp_mode_q) begin
        cand_act[i] = (i == 0);
        cand_vec[i] = (i == 0) ? irq_pin : '0;
      end else begin
        cand_act[i] = pin_act[i];
        cand_vec[i] = pin_vec_q[i];
      end
    end
    for (int t = 0; t < NTMR; t++) begin
      cand_act[NPINS+t] = tmr_act[t];
      cand_vec[NPINS+t] = tmr_vec_q[t];
    end
  end

  irq_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .act   (cand_act),
    .vecs  (cand_vec),
    .floor (cur_pri),
    .found (win_found),
    .idx   (win_idx),
    .vec   (win_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      irq_vec   <= '0;
      src_q     <= '0;
      nmi_sel_q <= 1'b0;
    end else if (nmi_act) begin
      irq_req   <= 1'b1;
      irq_vec   <= NMI_VEC;
      src_q     <= '0;
      nmi_sel_q <= 1'b1;
    end else begin
      irq_req   <= win_found;
      irq_vec   <= win_found ? win_vec : '0;
      src_q     <= win_idx;
      nmi_sel_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_pkg::*;
#(
  parameter int   NTMR    = 2,
  parameter vec_t NMI_VEC = 8'hF8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VEC_W-1:0] irq_pin,
  input logic [PRI_W-1:0] cur_pri,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             exp_mode,
  input logic             nmi_act,
  input logic [NTMR-1:0]  tmr_act,
  input logic             nmi_sel
);
  // R1: the cycle after reset is seen, the output is idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!irq_req && irq_vec == '0));

  // R4: a presented maskable vector outranks the priority sampled with it
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !nmi_sel) |-> (irq_vec[VEC_W-1:PRI_LSB] > $past(cur_pri)));

  // R6: no vector below 16 ever reaches the core
  p_valid_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (int'(irq_vec) >= MIN_VEC));

  // R8: a pending non-maskable request takes the next output slot
  p_nmi_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_act |=> (irq_req && nmi_sel && irq_vec == NMI_VEC));

  // R7: an eligible encoded vector with no competitor is passed through
  p_expanded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_mode && int'(irq_pin) >= MIN_VEC && irq_pin[VEC_W-1:PRI_LSB] > cur_pri &&
     !nmi_act && tmr_act == '0) |=> (irq_req && irq_vec == $past(irq_pin)));
endmodule

bind irq_prio_ctl irq_prio_chk #(.NTMR(NTMR), .NMI_VEC(NMI_VEC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_pin  (irq_pin),
  .cur_pri  (cur_pri),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .exp_mode (exp_mode_q),
  .nmi_act  (nmi_act),
  .tmr_act  (tmr_act),
  .nmi_sel  (nmi_sel_q)
);

// File: tb/sim_irq_prio_ctl.sv
module sim_irq_prio_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NTBL = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_pin = '0;
  logic [1:0] tmr_irq = '0;
  logic       nmi_in = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [8:0] cfg_wdata = '0;
  logic [4:0] cur_pri = '0;
  logic       irq_req;
  logic [7:0] irq_vec;
  logic       irq_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic cur_mode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctl u0 (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .tmr_irq(tmr_irq),
    .nmi_in(nmi_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cur_pri(cur_pri), .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  // {mode, pins, cur_pri, expected req, expected vector}
  localparam logic [22:0] TBL [NTBL] = '{
    {1'b0, 8'h00, 5'd0,  1'b0, 8'h00},
    {1'b0, 8'h01, 5'd0,  1'b1, 8'h40},
    {1'b0, 8'h01, 5'd8,  1'b0, 8'h00},
    {1'b0, 8'h01, 5'd7,  1'b1, 8'h40},
    {1'b0, 8'h0A, 5'd0,  1'b1, 8'h48},
    {1'b0, 8'h0B, 5'd0,  1'b1, 8'h48},
    {1'b0, 8'h10, 5'd0,  1'b0, 8'h00},
    {1'b0, 8'h25, 5'd0,  1'b1, 8'h80},
    {1'b0, 8'hA5, 5'd0,  1'b1, 8'hF0},
    {1'b0, 8'hA5, 5'd30, 1'b0, 8'h00},
    {1'b0, 8'h44, 5'd5,  1'b1, 8'h30},
    {1'b0, 8'h40, 5'd4,  1'b0, 8'h00},
    {1'b1, 8'h0F, 5'd0,  1'b0, 8'h00},
    {1'b1, 8'h10, 5'd0,  1'b1, 8'h10},
    {1'b1, 8'h10, 5'd2,  1'b0, 8'h00},
    {1'b1, 8'hC7, 5'd23, 1'b1, 8'hC7},
    {1'b1, 8'hC7, 5'd24, 1'b0, 8'h00},
    {1'b1, 8'h01, 5'd0,  1'b0, 8'h00}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic req_e, logic [7:0] vec_e);
    checks++;
    if (irq_req !== req_e || irq_vec !== vec_e) begin
      fails++;
      $display("FAIL %s: req=%0b vec=%02h, expected req=%0b vec=%02h",
               tag, irq_req, irq_vec, req_e, vec_e);
    end
  endtask

  task automatic cfg(logic [3:0] sel, logic [8:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic ack_once();
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R1..R10 run): cycles=50000, expected completion earlier");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    chk("R1 reset idle", 1'b0, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R1 idle after release", 1'b0, 8'h00);

    // R10: per-pin vectors, all level-triggered
    cfg(4'd0, 9'h040); cfg(4'd1, 9'h048); cfg(4'd2, 9'h030); cfg(4'd3, 9'h048);
    cfg(4'd4, 9'h00C); cfg(4'd5, 9'h080); cfg(4'd6, 9'h020); cfg(4'd7, 9'h0F0);

    // table: R2, R4, R5, R6, R7
    for (int k = 0; k < NTBL; k++) begin
      irq_pin = TBL[k][21:14];
      cur_pri = TBL[k][13:9];
      if (TBL[k][22] != cur_mode) begin
        cur_mode = TBL[k][22];
        cfg(4'd10, {8'h00, cur_mode});
      end
      step();
      chk($sformatf("R2/R4/R5/R6/R7 table row %0d", k), TBL[k][8], TBL[k][7:0]);
    end
    irq_pin = '0; cur_pri = '0;
    cfg(4'd10, 9'h000);
    step();
    chk("R7 back to dedicated idle", 1'b0, 8'h00);

    // R3: edge pin latched until acknowledged
    cfg(4'd0, 9'h140);
    irq_pin = 8'h01; step(); irq_pin = 8'h00;
    chk("R3 edge presented", 1'b1, 8'h40);
    step();
    chk("R3 edge still latched", 1'b1, 8'h40);
    ack_once();
    chk("R3 cleared by ack", 1'b0, 8'h00);
    step();
    chk("R3 stays cleared", 1'b0, 8'h00);

    // R4: blocked edge waits for priority to drop
    cur_pri = 5'd10;
    irq_pin = 8'h01; step(); irq_pin = 8'h00;
    step();
    chk("R4 blocked edge", 1'b0, 8'h00);
    cur_pri = 5'd0; step();
    chk("R4 released edge", 1'b1, 8'h40);
    ack_once();
    chk("R4 edge acked", 1'b0, 8'h00);

    // R2/R3: level pin survives ack, drops on release
    irq_pin = 8'h02; step();
    chk("R2 level held", 1'b1, 8'h48);
    ack_once();
    chk("R3 ack leaves level", 1'b1, 8'h48);
    irq_pin = 8'h00; step();
    chk("R2 level released", 1'b0, 8'h00);

    // R8: non-maskable
    irq_pin = 8'h80; cur_pri = 5'd31; step();
    chk("R4 pin7 blocked at 31", 1'b0, 8'h00);
    nmi_in = 1'b1; step(); nmi_in = 1'b0;
    chk("R8 nmi ignores priority", 1'b1, 8'hF8);
    step();
    chk("R8 nmi latched", 1'b1, 8'hF8);
    cur_pri = 5'd0; step();
    chk("R8 nmi outranks pin7", 1'b1, 8'hF8);
    ack_once();
    chk("R8 nmi acked, pin7 next", 1'b1, 8'hF0);
    irq_pin = 8'h00; step();
    chk("R2 pin7 released", 1'b0, 8'h00);

    // R9/R5: timers, equal priority, lower index first
    cfg(4'd8, 9'h060); cfg(4'd9, 9'h061);
    tmr_irq = 2'b11; step(); tmr_irq = 2'b00;
    chk("R9/R5 timer0 first", 1'b1, 8'h60);
    step();
    chk("R9 timers latched", 1'b1, 8'h60);
    ack_once();
    chk("R9 timer1 after ack", 1'b1, 8'h61);
    ack_once();
    chk("R9 both acked", 1'b0, 8'h00);

    // R10: rewrite a pin vector
    cfg(4'd6, 9'h0E8);
    irq_pin = 8'h40; step();
    chk("R10 rewritten vector", 1'b1, 8'hE8);

    // R1: reset mid-operation restores defaults
    irq_pin = 8'h02; step();
    chk("R5 pin1 beats nothing else", 1'b1, 8'h48);
    rst_n = 1'b0; step();
    chk("R1 reset clears output", 1'b0, 8'h00);
    rst_n = 1'b1; step();
    chk("R1 config defaults disable pin", 1'b0, 8'h00);

    summary();
    $finish;
  end
endmodule